// File: doc/BRIEF.md
# TDM Transmit Slot Gate

This block follows the time slots of a time-division-multiplexed serial frame and decides, for each slot, whether the transmitter takes part in it and whether the transmitted bits are actually driven onto the data line. The decision has two levels. A slot is either enabled or disabled. An enabled slot is then either driven or masked. A disabled slot takes no word from the transmit buffer and raises no transmit-ready event. A masked slot consumes its word, but the data pin stays high impedance for the whole slot.

A frame sync restarts the slot count at channel 0. A word-boundary strobe then steps the count up to a ceiling of channel 127. Four selection modes are supported. One of them is symmetric: it takes its enables from the receive channel selection, so that the transmit and receive directions use the same slots.

The mode, the 32/128 range select and both selection vectors are captured at frame sync. Changes to them therefore take effect only from the next frame onward. The shifter, the buffers and the clock generation sit outside this block and follow `tx_en_o` and `drive_en_o`.

Top module: `tdm_tx_slot_gate`

## Requirements
- R1: A cycle with `fsync_i` high makes `chan_o` 0 on the next clock, whatever `word_stb_i` is. A cycle with `word_stb_i` high and `fsync_i` low, while `chan_o` is below 127, makes `chan_o` one higher on the next clock.
- R2: When the captured mode is 2'b00, every slot has `tx_en_o`=1 and `drive_en_o`=1, regardless of the selection vectors.
- R3: When the captured mode is 2'b01, a slot has `tx_en_o` = `drive_en_o` = bit n of `tx_sel_i`, where n is the channel number.
- R4: When the captured mode is 2'b10, every slot has `tx_en_o`=1, and `drive_en_o` equals bit n of `tx_sel_i`.
- R5: When the captured mode is 2'b11, `tx_en_o` equals bit n of `rx_sel_i`, and `drive_en_o` is bit n of `rx_sel_i` AND bit n of `tx_sel_i`. In every mode, `drive_en_o` high implies `tx_en_o` high.
- R6: When `wide_sel_i` is captured as 0 (the 32-channel range), channels 32 to 127 behave as if their bits in both selection vectors were clear. When it is captured as 1, all 128 bits apply.
- R7: `mode_i`, `wide_sel_i`, `tx_sel_i` and `rx_sel_i` are sampled only in a cycle with `fsync_i` high. The slot that starts at that frame sync already uses the new values. Changes at any other time have no effect until the next frame sync.
- R8: A word strobe while `chan_o` is 127, with `fsync_i` low, leaves `chan_o`, `tx_en_o` and `drive_en_o` unchanged.
- R9: All three outputs are registered. They change exactly one clock after a frame sync or an advancing strobe, and they hold their values in every other cycle.
- R10: After reset, `chan_o`=0, `tx_en_o`=0 and `drive_en_o`=0, and the captured mode is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Selection mode: 00 all, 01 enable-select, 10 mask-select, 11 symmetric |
| wide_sel_i | input | 1 | 1 = 128 selectable channels, 0 = 32 |
| tx_sel_i | input | 128 | Transmit channel selection, bit n for channel n |
| rx_sel_i | input | 128 | Receive channel selection, bit n for channel n |
| fsync_i | input | 1 | Frame sync, one clock wide |
| word_stb_i | input | 1 | Word-boundary strobe, one clock wide |
| chan_o | output | 7 | Current channel number |
| tx_en_o | output | 1 | Slot is enabled (word taken, ready event raised) |
| drive_en_o | output | 1 | Data pin driven in this slot; low means high impedance |

## Verification
The assertions check the following on every cycle:
- the counter restart on frame sync and its single-step advance;
- the ceiling at 127;
- the rule that a masked or disabled slot never drives the line;
- the all-on behaviour of mode 00;
- the forced-clear range in 32-channel selection;
- that captured settings and outputs cannot move between frames or between strobes.

The exact per-mode truth table for arbitrary selection vectors, and the one-frame delay that follows a mid-frame configuration change, only come out of the bench's frames. In those frames an independent model is compared against the outputs every clock.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  typedef enum logic [1:0] {
    MODE_ALL      = 2'b00,
    MODE_EN_SEL   = 2'b01,
    MODE_MASK_SEL = 2'b10,
    MODE_SYM      = 2'b11
  } slot_mode_e;

  // Returns {enable, drive} for one slot from its two selection bits.
  function automatic logic [1:0] slot_verdict(slot_mode_e m, logic tx_bit, logic rx_bit);
    logic en, dr;
    unique case (m)
      MODE_ALL:      begin en = 1'b1;   dr = 1'b1;            end
      MODE_EN_SEL:   begin en = tx_bit; dr = tx_bit;          end
      MODE_MASK_SEL: begin en = 1'b1;   dr = tx_bit;          end
      default:       begin en = rx_bit; dr = rx_bit & tx_bit; end
    endcase
    return {en, dr};
  endfunction
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
  parameter int NUM_CH = 128,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fsync_i,
  input  logic            word_stb_i,
  output logic [CH_W-1:0] chan_q,
  output logic [CH_W-1:0] chan_nxt,
  output logic            step_o,
  output logic            update_o
);
  localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

  assign step_o   = word_stb_i && !fsync_i && (chan_q != LAST);
  assign update_o = fsync_i || step_o;
  assign chan_nxt = fsync_i ? '0 : (step_o ? chan_q + 1'b1 : chan_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_q <= '0;
    else        chan_q <= chan_nxt;
  end

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> chan_q == $past(chan_q) + 1'b1);
  p_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb_i && !fsync_i && chan_q == LAST) |=> chan_q == LAST);
endmodule

// File: rtl/tdm_slot_cfg.sv
module tdm_slot_cfg
  import tdm_slot_pkg::*;
#(
  parameter int NUM_CH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync_i,
  input  logic [1:0]        mode_i,
  input  logic              wide_i,
  input  logic [NUM_CH-1:0] tx_sel_i,
  input  logic [NUM_CH-1:0] rx_sel_i,
  output slot_mode_e        mode_q,
  output logic              wide_q,
  output logic [NUM_CH-1:0] tx_sel_q,
  output logic [NUM_CH-1:0] rx_sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_ALL;
      wide_q   <= 1'b0;
      tx_sel_q <= '0;
      rx_sel_q <= '0;
    end else if (fsync_i) begin
      mode_q   <= slot_mode_e'(mode_i);
      wide_q   <= wide_i;
      tx_sel_q <= tx_sel_i;
      rx_sel_q <= rx_sel_i;
    end
  end

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync_i |=> ($stable(mode_q) && $stable(wide_q) && $stable(tx_sel_q) && $stable(rx_sel_q)));
endmodule

// File: rtl/tdm_slot_decide.sv
module tdm_slot_decide
  import tdm_slot_pkg::*;
#(
  parameter int NUM_CH   = 128,
  parameter int SMALL_CH = 32,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  slot_mode_e        mode_i,
  input  logic              wide_i,
  input  logic [NUM_CH-1:0] tx_sel_i,
  input  logic [NUM_CH-1:0] rx_sel_i,
  input  logic [CH_W-1:0]   chan_i,
  output logic              en_o,
  output logic              dr_o
);
  logic in_range, tx_bit, rx_bit;

  assign in_range = wide_i || (int'(chan_i) < SMALL_CH);
  assign tx_bit   = tx_sel_i[chan_i] && in_range;
  assign rx_bit   = rx_sel_i[chan_i] && in_range;
  assign {en_o, dr_o} = slot_verdict(mode_i, tx_bit, rx_bit);
endmodule

// File: rtl/tdm_tx_slot_gate.sv
module tdm_tx_slot_gate
  import tdm_slot_pkg::*;
#(
  parameter int NUM_CH   = 128,
  parameter int SMALL_CH = 32,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              wide_sel_i,
  input  logic [NUM_CH-1:0] tx_sel_i,
  input  logic [NUM_CH-1:0] rx_sel_i,
  input  logic              fsync_i,
  input  logic              word_stb_i,
  output logic [CH_W-1:0]   chan_o,
  output logic              tx_en_o,
  output logic              drive_en_o
);
  logic [CH_W-1:0]   chan_nxt;
  logic              step, update;
  slot_mode_e        cfg_mode, eff_mode;
  logic              cfg_wide, eff_wide;
  logic [NUM_CH-1:0] cfg_tx, cfg_rx, eff_tx, eff_rx;
  logic              verdict_en, verdict_dr;

  tdm_slot_counter #(.NUM_CH(NUM_CH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .word_stb_i(word_stb_i),
    .chan_q(chan_o), .chan_nxt(chan_nxt), .step_o(step), .update_o(update));

  tdm_slot_cfg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .mode_i(mode_i),
    .wide_i(wide_sel_i), .tx_sel_i(tx_sel_i), .rx_sel_i(rx_sel_i),
    .mode_q(cfg_mode), .wide_q(cfg_wide), .tx_sel_q(cfg_tx), .rx_sel_q(cfg_rx));

  // The slot opened by a frame sync is judged with the settings captured there.
  assign eff_mode = fsync_i ? slot_mode_e'(mode_i) : cfg_mode;
  assign eff_wide = fsync_i ? wide_sel_i : cfg_wide;
  assign eff_tx   = fsync_i ? tx_sel_i   : cfg_tx;
  assign eff_rx   = fsync_i ? rx_sel_i   : cfg_rx;

  tdm_slot_decide #(.NUM_CH(NUM_CH), .SMALL_CH(SMALL_CH)) u_dec (
    .mode_i(eff_mode), .wide_i(eff_wide), .tx_sel_i(eff_tx), .rx_sel_i(eff_rx),
    .chan_i(chan_nxt), .en_o(verdict_en), .dr_o(verdict_dr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_o    <= 1'b0;
      drive_en_o <= 1'b0;
    end else if (update) begin
      tx_en_o    <= verdict_en;
      drive_en_o <= verdict_dr;
    end
  end

  p_frame_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_i |=> chan_o == '0);
  p_drive_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en_o |-> tx_en_o);
  p_all_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cfg_mode == MODE_ALL) |=> (tx_en_o && drive_en_o));
  p_small_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cfg_mode != MODE_ALL && !cfg_wide && int'(chan_nxt) >= SMALL_CH) |=> !drive_en_o);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync_i && !word_stb_i) |=> ($stable(chan_o) && $stable(tx_en_o) && $stable(drive_en_o)));
endmodule

// File: tb/test_tdm_tx_slot_gate.sv
module test_tdm_tx_slot_gate;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic         wide_sel_i = 1'b0;
  logic [127:0] tx_sel_i = '0;
  logic [127:0] rx_sel_i = '0;
  logic         fsync_i = 1'b0;
  logic         word_stb_i = 1'b0;
  logic [6:0]   chan_o;
  logic         tx_en_o, drive_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state.
  int       m_mode = 0;
  bit       m_wide = 0;
  bit [127:0] m_tx = '0, m_rx = '0;
  int       m_ch = 0;
  bit       m_en = 0, m_dr = 0;
  bit       cfg_changed = 0;
  bit       last_stb = 0, last_fs = 0;

  always #2 clk = ~clk;

  tdm_tx_slot_gate i_tdm_tx_slot_gate (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wide_sel_i(wide_sel_i),
    .tx_sel_i(tx_sel_i), .rx_sel_i(rx_sel_i), .fsync_i(fsync_i),
    .word_stb_i(word_stb_i), .chan_o(chan_o), .tx_en_o(tx_en_o),
    .drive_en_o(drive_en_o));

  function automatic void judge(int md, bit wd, bit [127:0] tv, bit [127:0] rv, int ch,
                                output bit en, output bit dr);
    bit t, r;
    t = (wd || ch < 32) ? tv[ch] : 1'b0;
    r = (wd || ch < 32) ? rv[ch] : 1'b0;
    if (md == 0)      begin en = 1; dr = 1; end
    else if (md == 1) begin en = t; dr = t; end
    else if (md == 2) begin en = 1; dr = t; end
    else              begin en = r; dr = r && t; end
  endfunction

  always @(posedge clk) begin
    last_fs  <= fsync_i;
    last_stb <= word_stb_i;
    if (rst_n) begin
      if (fsync_i) begin
        m_mode = mode_i; m_wide = wide_sel_i; m_tx = tx_sel_i; m_rx = rx_sel_i;
        m_ch = 0;
        judge(m_mode, m_wide, m_tx, m_rx, 0, m_en, m_dr);
        cfg_changed = 0;
      end else if (word_stb_i && m_ch < 127) begin
        m_ch = m_ch + 1;
        judge(m_mode, m_wide, m_tx, m_rx, m_ch, m_en, m_dr);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (chan %0d)", req, act, exp, m_ch);
    end
  endtask

  function automatic string tag();
    if (cfg_changed)                        return "R7";
    if (m_ch == 127 && last_stb && !last_fs) return "R8";
    if (!last_stb && !last_fs)              return "R9";
    if (m_mode != 0 && !m_wide && m_ch >= 32) return "R6";
    case (m_mode)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic compare();
    string t;
    t = tag();
    check("R1 chan", int'(chan_o), m_ch);
    check({t, " tx_en"}, int'(tx_en_o), int'(m_en));
    check({t, " drive_en"}, int'(drive_en_o), int'(m_dr));
  endtask

  task automatic cyc(bit fs, bit stb);
    fsync_i = fs; word_stb_i = stb;
    @(negedge clk);
    fsync_i = 0; word_stb_i = 0;
    compare();
  endtask

  task automatic frame(int md, bit wd, bit [127:0] tv, bit [127:0] rv, bit mid_change);
    mode_i = 2'(md); wide_sel_i = wd; tx_sel_i = tv; rx_sel_i = rv;
    cyc(1, 0);
    for (int k = 0; k < 131; k++) begin
      if (mid_change && k == 20) begin
        mode_i = ~mode_i; wide_sel_i = ~wide_sel_i; tx_sel_i = ~tx_sel_i; rx_sel_i = ~rx_sel_i;
        cfg_changed = 1;
      end
      cyc(0, 1);
      if (k % 7 == 3) cyc(0, 0);
    end
  endtask

  initial begin
    bit [127:0] a, b;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 chan", int'(chan_o), 0);
    check("R10 tx_en", int'(tx_en_o), 0);
    check("R10 drive_en", int'(drive_en_o), 0);
    rst_n = 1;
    cyc(0, 1);  // strobe before any frame: counter steps with captured mode 00
    a = {$urandom, $urandom, $urandom, $urandom};
    b = {$urandom, $urandom, $urandom, $urandom};
    for (int md = 0; md < 4; md++) begin
      frame(md, 1'b1, a, b, 1'b0);
      frame(md, 1'b0, a, b, 1'b0);
    end
    frame(1, 1'b0, {128{1'b1}}, {128{1'b1}}, 1'b0);
    frame(3, 1'b1, a, b, 1'b1);
    frame(2, 1'b0, b, a, 1'b1);
    // R1: frame sync wins over a simultaneous strobe
    cyc(0, 1);
    cyc(1, 1);
    check("R1 fsync priority", int'(chan_o), 0);
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected done", n);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule